// File: doc/BRIEF.md
# Dual-Bank Register File with Bank Exchange

This block holds the working registers of an 8-bit processor core. There are two banks of general registers, each with six 8-bit registers grouped into three 16-bit pairs. There are also two accumulator/flag pairs. Two 1-bit selects pick the live general bank and the live accumulator/flag pair. An exchange never copies data. It flips one select in a single cycle, and the other bank keeps its contents.

The datapath reaches the live registers through one 16-bit write port and two combinational 16-bit read ports. Every port is addressed by a 2-bit pair selector. A byte enable on the write port turns it into an 8-bit write of either half of a pair. On the read side, the caller takes the byte it needs out of the 16-bit result. Instruction decode and flag computation are outside this block.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears both bank selects to 0, so `gp_bank` and `af_bank` both read 0 afterwards. Register contents are not reset.
- R2: Pair selector encoding is 0, 1 or 2 for the three general pairs and 3 for the accumulator/flag pair. A pair reads with its first-named register (or the accumulator) in bits 15:8 and its second register (or the flags) in bits 7:0.
- R3: Write byte enable bit 1 writes bits 15:8 and bit 0 writes bits 7:0. A byte whose enable is low keeps its old value.
- R4: `swap_gp` high at a rising edge toggles `gp_bank`. Two such swaps bring it back to its starting value.
- R5: `swap_af` toggles only `af_bank`, and `swap_gp` toggles only `gp_bank`. Reads of the other kind of register are unaffected by the other swap.
- R6: The inactive bank keeps its contents. Data written before a swap reads back unchanged after swapping back.
- R7: A write in the same cycle as a swap of the bank it addresses lands in the bank that was active before the toggle.
- R8: The two read ports have independent selectors. Each shows the addressed pair of the live bank in the same cycle, with no clock edge needed.
- R9: With `wr_en` low, nothing in the file changes, whatever is on the other write inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the bank selects |
| swap_gp | input | 1 | Exchange the general register bank |
| swap_af | input | 1 | Exchange the accumulator/flag pair |
| wr_en | input | 1 | Write strobe |
| wr_pair | input | 2 | Pair selector for the write |
| wr_be | input | 2 | Byte enables: bit 1 high byte, bit 0 low byte |
| wr_data | input | 16 | Write data |
| rd_a_sel | input | 2 | Pair selector for read port A |
| rd_a_data | output | 16 | Read port A data |
| rd_b_sel | input | 2 | Pair selector for read port B |
| rd_b_data | output | 16 | Read port B data |
| gp_bank | output | 1 | Current general bank select |
| af_bank | output | 1 | Current accumulator/flag select |

## Verification
On every cycle, the assertions check that each select toggles exactly when its swap input is high and holds otherwise. They also check that reset clears both selects, that the bank not addressed by a write keeps its contents, and that a write issued together with a swap reaches the pre-toggle bank. Only the bench scenarios can show the rest: byte placement inside a pair, the merge of partial writes, data surviving a round trip through the other bank, independent swaps of the two kinds of bank, and concurrent reads on both ports.

// File: rtl/bregs_pkg.sv
package bregs_pkg;
    localparam int BYTE_W = 8;
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int NUM_GP = 3;
    localparam int NUM_BANKS = 2;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        PAIR_0    = 2'd0,
        PAIR_1    = 2'd1,
        PAIR_2    = 2'd2,
        PAIR_ACCF = 2'd3
    } pair_e;

    typedef logic [PAIR_W-1:0] pair_t;

    typedef struct packed {
        logic  en;
        pair_e sel;
        logic [1:0] be;
        pair_t data;
    } wr_req_t;

    // Replace only the enabled bytes of a pair
    function automatic pair_t merge_bytes(pair_t old_v, pair_t new_v, logic [1:0] be);
        pair_t r;
        r[PAIR_W-1:BYTE_W] = be[1] ? new_v[PAIR_W-1:BYTE_W] : old_v[PAIR_W-1:BYTE_W];
        r[BYTE_W-1:0]      = be[0] ? new_v[BYTE_W-1:0]      : old_v[BYTE_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/bregs_select.sv
module bregs_select (
    input  logic clk,
    input  logic rst,
    input  logic swap,
    output logic sel
);
    always_ff @(posedge clk) begin
        if (rst)       sel <= 1'b0;
        else if (swap) sel <= ~sel;
    end

    // R4
    sel_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        swap |=> (sel != $past(sel)));

    // R5
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !swap |=> $stable(sel));

    // R1
    sel_reset_chk: assert property (@(posedge clk)
        rst |=> (sel == 1'b0));
endmodule

// File: rtl/bregs_bank.sv
module bregs_bank
    import bregs_pkg::*;
#(
    parameter int NP = 3
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [IDX_W-1:0]           widx,
    input  logic [1:0]                 be,
    input  pair_t                      wdata,
    output logic [NP-1:0][PAIR_W-1:0]  q
);
    localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1;

    for (genvar i = 0; i < NP; i++) begin : g_pair
        always_ff @(posedge clk) begin
            if (we && (widx == IDX_W'(i)))
                q[i] <= merge_bytes(q[i], wdata, be);
        end
    end
endmodule

// File: rtl/bregs_rdmux.sv
module bregs_rdmux
    import bregs_pkg::*;
(
    input  logic [NUM_GP-1:0][PAIR_W-1:0] gp,
    input  pair_t                         af,
    input  logic [SEL_W-1:0]              sel,
    output pair_t                         data
);
    always_comb begin
        case (pair_e'(sel))
            PAIR_0:  data = gp[0];
            PAIR_1:  data = gp[1];
            PAIR_2:  data = gp[2];
            default: data = af;
        endcase
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bregs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        swap_gp,
    input  logic        swap_af,
    input  logic        wr_en,
    input  logic [1:0]  wr_pair,
    input  logic [1:0]  wr_be,
    input  logic [15:0] wr_data,
    input  logic [1:0]  rd_a_sel,
    output logic [15:0] rd_a_data,
    input  logic [1:0]  rd_b_sel,
    output logic [15:0] rd_b_data,
    output logic        gp_bank,
    output logic        af_bank
);
    localparam int NRD = 2;

    wr_req_t req;
    assign req = '{en: wr_en, sel: pair_e'(wr_pair), be: wr_be, data: wr_data};

    logic to_af;
    assign to_af = (req.sel == PAIR_ACCF);

    bregs_select u_gsel (.clk(clk), .rst(rst), .swap(swap_gp), .sel(gp_bank));
    bregs_select u_asel (.clk(clk), .rst(rst), .swap(swap_af), .sel(af_bank));

    logic [NUM_GP-1:0][PAIR_W-1:0] gp_q [NUM_BANKS];
    logic [0:0][PAIR_W-1:0]        af_q [NUM_BANKS];

    // Writes use the select value before any toggle at this edge
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bregs_bank #(.NP(NUM_GP)) u_gp (
            .clk(clk),
            .we(req.en && !to_af && (gp_bank == 1'(b))),
            .widx(req.sel),
            .be(req.be),
            .wdata(req.data),
            .q(gp_q[b])
        );
        bregs_bank #(.NP(1)) u_af (
            .clk(clk),
            .we(req.en && to_af && (af_bank == 1'(b))),
            .widx(1'b0),
            .be(req.be),
            .wdata(req.data),
            .q(af_q[b])
        );
    end

    logic [NUM_GP-1:0][PAIR_W-1:0] gp_live;
    pair_t                         af_live;
    assign gp_live = gp_q[gp_bank];
    assign af_live = af_q[af_bank][0];

    logic [NRD-1:0][SEL_W-1:0] rsel;
    pair_t                     rdat [NRD];
    assign rsel = {rd_b_sel, rd_a_sel};

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        bregs_rdmux u_mux (.gp(gp_live), .af(af_live), .sel(rsel[k]), .data(rdat[k]));
    end

    assign rd_a_data = rdat[0];
    assign rd_b_data = rdat[1];

    // R6
    idle_gp0_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && !to_af && !gp_bank) |=> $stable(gp_q[0]));

    // R6
    idle_af1_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && to_af && af_bank) |=> $stable(af_q[1]));

    // R7
    swap_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && swap_gp && !gp_bank && wr_pair == 2'd0 && wr_be == 2'b11)
        |=> (gp_q[0][0] == $past(wr_data)));
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        swap_gp = 0, swap_af = 0, wr_en = 0;
    logic [1:0]  wr_pair = 0, wr_be = 0, rd_a_sel = 0, rd_b_sel = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_a_data, rd_b_data;
    logic        gp_bank, af_bank;

    banked_regfile uut (.*);

    always #5 clk = ~clk;

    typedef struct {
        int          port;   // 0 = A, 1 = B, 2 = bank selects
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          n_run = 0, n_fail = 0;
    logic [15:0] m_gp [2][3];
    logic [15:0] m_af [2];
    bit          m_g = 0, m_a = 0;
    bit          done = 0;

    // Monitor: compare every queued expectation away from the clock edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb.pop_front();
            case (it.port)
                0: act = rd_a_data;
                1: act = rd_b_data;
                default: act = {14'd0, af_bank, gp_bank};
            endcase
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    function automatic logic [15:0] mrg(logic [15:0] o, logic [15:0] n, logic [1:0] be);
        return {be[1] ? n[15:8] : o[15:8], be[0] ? n[7:0] : o[7:0]};
    endfunction

    task automatic drive(input bit en, input int pair, input logic [1:0] be,
                         input logic [15:0] d, input bit sg, input bit sa);
        @(posedge clk); #1;
        wr_en = en; wr_pair = 2'(pair); wr_be = be; wr_data = d;
        swap_gp = sg; swap_af = sa;
        if (en) begin
            if (pair == 3) m_af[m_a] = mrg(m_af[m_a], d, be);
            else           m_gp[m_g][pair] = mrg(m_gp[m_g][pair], d, be);
        end
        if (sg) m_g = ~m_g;
        if (sa) m_a = ~m_a;
    endtask

    function automatic logic [15:0] mexp(int s);
        return (s == 3) ? m_af[m_a] : m_gp[m_g][s];
    endfunction

    task automatic rd(input int sa, input int sb_sel, input string tag);
        @(posedge clk); #1;
        wr_en = 0; swap_gp = 0; swap_af = 0;
        rd_a_sel = 2'(sa); rd_b_sel = 2'(sb_sel);
        sb.push_back('{0, mexp(sa), tag});
        sb.push_back('{1, mexp(sb_sel), tag});
    endtask

    task automatic banks(input string tag);
        @(posedge clk); #1;
        wr_en = 0; swap_gp = 0; swap_af = 0;
        sb.push_back('{2, {14'd0, m_a, m_g}, tag});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        banks("R1 reset selects");

        drive(1, 0, 2'b11, 16'h1234, 0, 0);
        rd(0, 0, "R2 pair layout");
        drive(1, 1, 2'b10, 16'hAB00, 0, 0);
        drive(1, 1, 2'b01, 16'h77CD, 0, 0);
        rd(1, 0, "R3 byte enables");
        drive(1, 2, 2'b11, 16'h5678, 0, 0);
        drive(1, 3, 2'b11, 16'h9A01, 0, 0);
        rd(3, 2, "R8 two ports");
        rd(2, 3, "R8 swapped selectors");

        drive(0, 0, 2'b00, 16'h0000, 1, 0);
        banks("R4 gp swap");
        drive(1, 0, 2'b11, 16'h1111, 0, 0);
        drive(1, 2, 2'b11, 16'h2222, 0, 0);
        rd(0, 2, "R4 other bank written");
        rd(3, 1, "R5 af unaffected by gp swap");
        drive(0, 0, 2'b00, 16'h0000, 1, 0);
        banks("R4 double swap returns");
        rd(0, 1, "R6 bank 0 retained");

        drive(0, 0, 2'b00, 16'h0000, 0, 1);
        banks("R5 af swap alone");
        rd(0, 2, "R5 gp unaffected by af swap");
        drive(1, 3, 2'b11, 16'h4242, 0, 0);
        rd(3, 0, "R5 second af pair");
        drive(0, 0, 2'b00, 16'h0000, 0, 1);
        rd(3, 3, "R6 af pair retained");

        drive(1, 2, 2'b11, 16'hBEEF, 1, 0);
        rd(2, 0, "R7 write went to old bank");
        drive(0, 0, 2'b00, 16'h0000, 1, 0);
        rd(2, 0, "R7 old bank holds write");

        drive(0, 0, 2'b11, 16'hFFFF, 0, 0);
        drive(0, 3, 2'b11, 16'hFFFF, 0, 0);
        rd(0, 3, "R9 disabled write ignored");
        banks("R9 final selects");

        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule